// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt Vector Entry

This block is a countdown timer for a processor's local interrupt unit, programmed through a small word-indexed register bus. Software chooses a clock divider and writes a control word that holds an 8-bit interrupt vector, a mask flag and a repeat flag. Writing a start value then launches the countdown. The counter steps down once per divided clock tick. When it reaches zero, the block emits a one-cycle interrupt request that carries the programmed vector, unless the mask flag is set.

With the repeat flag set, the counter reloads from the start value and runs again, which gives a steady periodic tick. With the flag clear, the counter stops at zero. Software can read the start value, the control word, the divider setting and the live count at any time. Deciding which interrupt the core takes, and when it accepts it, is handled outside this block.

Top module: `lvt_countdown_timer`

## Requirements
- R1: After reset, the control word reads 0x0001_0000 (masked, one-shot, vector 0), the start value, the live count and the divider all read 0, and no interrupt request is raised.
- R2: The control word sits at word index 0xC8. Bits 7:0 hold the vector, bit 16 is the mask and bit 17 selects repeat mode. All other bits read back as 0.
- R3: The divider sits at word index 0xF8. Its bits 3, 1 and 0 form a 3-bit code {b3,b1,b0}. Code 3'b111 (for example 0xB) divides by 1, and any other code c divides by 2^(c+1), from 2 up to 128. Only bits 3, 1 and 0 read back.
- R4: Writing value V to the start register (index 0xE0) loads the live count with V and restarts the divider phase. With divide ratio D, the live count reads V - floor(n/D) n cycles after the write edge, until it reaches zero.
- R5: In one-shot mode the count reaches 0 at cycle V*D after the write and stays at 0. No further request follows.
- R6: In repeat mode, when the count steps from 1, it reloads V. Requests then occur every V*D cycles.
- R7: Each expiry gives `irq_req` high for exactly one cycle, in the cycle that follows the expiry edge. During that cycle `irq_vector` equals control bits 7:0; outside a request it reads 0.
- R8: While the mask bit is set, no request is raised, but the count keeps running and reloading as usual.
- R9: Writing 0 to the start register stops the timer. The live count reads 0 and no request follows.
- R10: The live count (index 0xE4) is read-only. A write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_idx | input | 8 | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, available in the same cycle |
| irq_req | output | 1 | One-cycle interrupt request on expiry |
| irq_vector | output | 8 | Vector that goes with `irq_req` |

## Verification
The bench runs every divide code and compares the live count after an odd number of cycles. A divider that is one cycle off, or that drops the restart on a new start value, would show up as a count off by one. It measures the exact cycle of the first request and the spacing between requests. A design that reloads one step late, or that pulses for more than one cycle, would show the wrong period or the wrong number of pulses. It also checks that a masked timer stays silent while its count still moves, that a zero start value halts the timer, and that a write to the live count leaves it untouched. It checks that unused control and divider bits read as zero.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;
  localparam logic [7:0] IDX_CTRL  = 8'hC8;
  localparam logic [7:0] IDX_START = 8'hE0;
  localparam logic [7:0] IDX_LIVE  = 8'hE4;
  localparam logic [7:0] IDX_DIV   = 8'hF8;

  localparam int MASK_BIT   = 16;
  localparam int REPEAT_BIT = 17;

  typedef struct packed {
    logic       repeat_en;
    logic       mask;
    logic [7:0] vector;
  } ctrl_word_t;

  localparam logic [2:0] DIV_BY_ONE = 3'b111;
endpackage

// File: rtl/timer_regfile.sv
module timer_regfile
  import lvt_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  live_count,
  output ctrl_word_t        ctrl,
  output logic [CNT_W-1:0]  start_val,
  output logic [2:0]        div_code,
  output logic              start_wr,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(IDX_CTRL);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(IDX_START);
  localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(IDX_LIVE);
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(IDX_DIV);

  ctrl_word_t       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] start_q, start_d;
  logic [2:0]       div_q, div_d;
  logic             ctrl_wr, div_wr;

  wire unused_wbits = ^{wdata[31:18], wdata[15:8], wdata[2]};

  assign ctrl_wr  = wr_en && (idx == A_CTRL);
  assign div_wr   = wr_en && (idx == A_DIV);
  assign start_wr = wr_en && (idx == A_START);

  always_comb begin
    ctrl_d  = ctrl_q;
    start_d = start_q;
    div_d   = div_q;
    if (ctrl_wr) begin
      ctrl_d.repeat_en = wdata[REPEAT_BIT];
      ctrl_d.mask      = wdata[MASK_BIT];
      ctrl_d.vector    = wdata[7:0];
    end
    if (start_wr) start_d = CNT_W'(wdata);
    if (div_wr)   div_d   = {wdata[3], wdata[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '{repeat_en: 1'b0, mask: 1'b1, vector: 8'h00};
      start_q <= '0;
      div_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= start_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      A_CTRL: begin
        rdata[REPEAT_BIT] = ctrl_q.repeat_en;
        rdata[MASK_BIT]   = ctrl_q.mask;
        rdata[7:0]        = ctrl_q.vector;
      end
      A_START: rdata = 32'(start_q);
      A_LIVE:  rdata = 32'(live_count);
      A_DIV:   rdata = {28'd0, div_q[2], 1'b0, div_q[1:0]};
      default: rdata = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign start_val = start_q;
  assign div_code  = div_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q)); // R2
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wr |=> $stable(div_q)); // R3
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import lvt_timer_pkg::*;
#(
  parameter int MAX_DIV_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       tick
);
  localparam int PRE_W = MAX_DIV_LOG2;

  logic [PRE_W-1:0] phase_q, phase_d, last_phase;

  always_comb begin
    if (code == DIV_BY_ONE) last_phase = '0;
    else                    last_phase = PRE_W'((1 << (int'(code) + 1)) - 1);
  end

  assign tick = !restart && (phase_q >= last_phase);

  always_comb begin
    phase_d = phase_q;
    if (restart)                  phase_d = '0;
    else if (phase_q >= last_phase) phase_d = '0;
    else                          phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0)); // R4
endmodule

// File: rtl/timer_downcounter.sv
module timer_downcounter
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  ctrl_word_t       ctrl,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic [7:0]       irq_vec
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic [7:0]       vec_q, vec_d;
  logic             step, expire;

  assign step   = tick && !load && (cnt_q != '0);
  assign expire = step && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (expire) cnt_d = ctrl.repeat_en ? reload_val : '0;
    else if (step)   cnt_d = cnt_q - 1'b1;
    irq_d = expire && !ctrl.mask;
    vec_d = irq_d ? ctrl.vector : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      vec_q <= vec_d;
    end
  end

  assign count   = cnt_q;
  assign irq     = irq_q;
  assign irq_vec = vec_q;

  AST_ZERO_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0 && !irq_q)); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && cnt_q == CNT_W'(1) && ctrl.repeat_en) |=> (cnt_q == reload_val)); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mask |=> !irq_q); // R8
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (vec_q == 8'h00)); // R7
endmodule

// File: rtl/lvt_countdown_timer.sv
module lvt_countdown_timer
  import lvt_timer_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int CNT_W        = 32,
  parameter int MAX_DIV_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_req,
  output logic [7:0]        irq_vector
);
  ctrl_word_t       ctrl;
  logic [CNT_W-1:0] start_val, live_count;
  logic [2:0]       div_code;
  logic             start_wr, tick;

  timer_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .live_count(live_count), .ctrl(ctrl), .start_val(start_val),
    .div_code(div_code), .start_wr(start_wr), .rdata(reg_rdata)
  );

  timer_prescaler #(.MAX_DIV_LOG2(MAX_DIV_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start_wr), .code(div_code), .tick(tick)
  );

  timer_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_wr), .load_val(CNT_W'(reg_wdata)),
    .reload_val(start_val), .tick(tick), .ctrl(ctrl), .count(live_count),
    .irq(irq_req), .irq_vec(irq_vector)
  );
endmodule

// File: tb/tb_lvt_countdown_timer.sv
`timescale 1ns/1ps
module tb_lvt_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_idx = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  localparam logic [7:0] A_CTRL = 8'hC8, A_START = 8'hE0, A_LIVE = 8'hE4, A_DIV = 8'hF8;

  localparam int NV = 9;
  localparam logic [31:0] T_DIV  [NV] = '{32'hB, 32'h0, 32'h1, 32'h2, 32'h3, 32'h8, 32'h9, 32'hA, 32'hB};
  localparam logic [31:0] T_START[NV] = '{100, 100, 50, 20, 10, 10, 5, 3, 10};
  localparam int          T_WAIT [NV] = '{37, 37, 41, 65, 33, 97, 200, 300, 25};
  localparam logic [31:0] T_EXP  [NV] = '{63, 82, 40, 12, 8, 7, 2, 1, 0};

  always #10 clk = ~clk;

  lvt_countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vector(irq_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_idx = a;
    #1;
    d = reg_rdata;
  endtask

  // Counts pulses over `len` cycles; records the first pulse cycle and any vector mismatch
  task automatic watch(input int len, input logic [7:0] vec, output int pulses,
                       output int first, output int badvec);
    pulses = 0; first = -1; badvec = 0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (irq_req) begin
        pulses++;
        if (first < 0) first = k;
        if (irq_vector !== vec) badvec++;
      end else if (irq_vector !== 8'h00) badvec++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p, f, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0001_0000);
    rd(A_START, v); check("R1 start", v, 0);
    rd(A_LIVE, v);  check("R1 live", v, 0);
    rd(A_DIV, v);   check("R1 div", v, 0);
    check("R1 irq", {31'd0, irq_req}, 0);

    // R4 / R3: table of divide codes, masked one-shot
    wr(A_CTRL, 32'h0001_0000);
    for (int i = 0; i < NV; i++) begin
      wr(A_DIV, T_DIV[i]);
      wr(A_START, T_START[i]);
      repeat (T_WAIT[i]) @(negedge clk);
      rd(A_LIVE, v);
      check($sformatf("R4 R3 table row %0d", i), v, T_EXP[i]);
    end

    // R2 control readback, R3 divider readback
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R2 ctrl bits", v, 32'h0003_00FF);
    wr(A_DIV, 32'hFFFF_FFFF);  rd(A_DIV, v);  check("R3 div bits", v, 32'h0000_000B);

    // R5 R7 one-shot, unmasked, vector 0x5A, divide by 1, V=5
    wr(A_CTRL, 32'h0000_005A);
    wr(A_START, 5);
    watch(20, 8'h5A, p, f, b);
    check("R5 pulse count", p, 1);
    check("R7 first pulse cycle", f, 5);
    check("R7 vector", b, 0);
    rd(A_LIVE, v); check("R5 stays zero", v, 0);

    // R6 repeat mode, divide by 2, V=4: period 8
    wr(A_DIV, 32'h0);
    wr(A_CTRL, 32'h0002_0033);
    wr(A_START, 4);
    watch(26, 8'h33, p, f, b);
    check("R6 pulse count", p, 3);
    check("R6 first pulse", f, 8);
    check("R7 repeat vector", b, 0);

    // R8 masked repeat: silent, count keeps running (div 1, V=3, 10 cycles -> 2)
    wr(A_DIV, 32'hB);
    wr(A_CTRL, 32'h0003_0044);
    wr(A_START, 3);
    watch(10, 8'h44, p, f, b);
    check("R8 masked pulses", p, 0);
    rd(A_LIVE, v); check("R8 count runs", v, 2);

    // R9 zero start halts an unmasked running timer
    wr(A_CTRL, 32'h0002_0011);
    wr(A_START, 6);
    repeat (2) @(negedge clk);
    wr(A_START, 0);
    rd(A_LIVE, v); check("R9 live zero", v, 0);
    watch(20, 8'h11, p, f, b);
    check("R9 no pulse", p, 0);

    // R10 live count is read-only
    wr(A_CTRL, 32'h0001_0000);
    wr(A_START, 1000);
    wr(A_LIVE, 5);
    rd(A_LIVE, v); check("R10 write ignored", v, 999);
    rd(A_START, v); check("R10 start untouched", v, 1000);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule